// File: doc/BRIEF.md
# Pipelined Quantizer Digital Correction

This block sits behind a nine-stage pipelined quantizer. Each stage produces a 2-bit decision per sample, and each stage reports one sub-clock later than the stage ahead of it. The block runs on the sub-clock, which is twice the sample rate. It delays the decisions of every stage by a different amount so that all nine decisions of one sample arrive together. It then merges them by shifted overlap-add. Adjacent stages share one redundant bit, so carries out of the later stages correct the earlier, coarser decisions.

The merged value is clamped to the 10-bit code range. It is delayed so that the whole digital path spans 13 sub-clock edges, which is 6.5 sample periods. It is then held on the output until the next sample completes. The output format is straight offset binary by default. Raising the format input inverts only the most significant bit, which gives two's complement. A separate control input floats all code pins.

The decision stream is qualified by `dec_valid`, which marks the sub-cycle in which stage 0 presents a new sample. The stream has no ready signal and cannot be back-pressured, because the quantizer cannot stall. Strobes must therefore be at least two sub-cycles apart, and the output likewise offers each code once with `out_valid` and never waits.

Top module: `adc_dig_correct`

## Requirements
- R1: For a sample whose stage-0 decision is captured with `dec_valid` at edge E, the decision of stage k (k = 0..8, stage 0 most significant) is taken from `stage_dec[2k+1:2k]` at edge E+k. The result is the sum of each stage value v_k times 2^(8-k).
- R2: `stage_dec` bits presented in any sub-cycle other than the one assigned to that stage for a sample have no effect on any output code.
- R3: A merged sum above 1023 is reported as 1023 and never wraps. An all-zero set of decisions yields code 0.
- R4: `out_valid` is high for exactly one cycle per strobe, immediately after edge E+13, and the code for that sample is on `code_o` in that cycle. Results leave in strobe order.
- R5: While `rst_n` is low, and afterwards until the first result arrives, `out_valid` is 0 and `code_o` reads 0 (with format and float inputs low).
- R6: With `twos_fmt` = 1, `code_o` bit 9 is the inverse of the offset-binary bit 9 and bits 8..0 are unchanged. The input acts without a clock edge.
- R7: With `hiz_en` = 1, all ten `code_o` pins are undriven. Clearing it restores the held code.
- R8: Between results, `code_o` keeps the last result (format applied).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sub-clock, twice the sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | Stage 0 presents a new sample this sub-cycle |
| stage_dec | input | 18 | Decisions; stage k in bits 2k+1:2k |
| twos_fmt | input | 1 | 1 = invert MSB for two's complement |
| hiz_en | input | 1 | 1 = float the code pins |
| out_valid | output | 1 | New code on `code_o` this cycle |
| code_o | output | 10 | Corrected code, tri-state |

## Verification
The hardest situation to reach is a sample whose nine decisions are scattered over nine sub-cycles. In that case each stage's bits for sample n share a cycle with other stages' bits for samples n-1 to n-4, while the bus carries unrelated bits in every slot not assigned to a stage. The bench first builds a per-cycle schedule in which each stage's value is written into its own slot and every unassigned slot is filled with hashed noise. It then plays the schedule back with occasional wider gaps between strobes. The sample set sweeps every stage through all four values alone and covers the first four stages exhaustively. It includes sums that exceed the range, so any misalignment or wrap shows up as a wrong code.

// File: rtl/adc_corr_pkg.sv
`timescale 1ns/1ps
package adc_corr_pkg;
  localparam int unsigned DEC_W = 2;
  typedef logic [DEC_W-1:0] stage_dec_t;
endpackage

// File: rtl/adc_delay_line.sv
`timescale 1ns/1ps
module adc_delay_line #(
  parameter int unsigned W     = 2,
  parameter int unsigned DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(DEPTH); i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < int'(DEPTH); i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[DEPTH-1];
endmodule

// File: rtl/adc_overlap_merge.sv
`timescale 1ns/1ps
module adc_overlap_merge
  import adc_corr_pkg::*;
#(
  parameter int unsigned NSTAGE = 9
) (
  input  logic [DEC_W*NSTAGE-1:0] dec_flat,
  output logic [NSTAGE:0]         code
);
  localparam int unsigned OUT_W = NSTAGE + 1;
  localparam int unsigned SUM_W = OUT_W + 1;
  localparam logic [SUM_W-1:0] CODE_MAX = SUM_W'((1 << OUT_W) - 1);

  logic [SUM_W-1:0] raw;

  // Each stage overlaps its neighbour by one bit: weight halves per stage.
  always_comb begin
    raw = '0;
    for (int k = 0; k < int'(NSTAGE); k++) begin
      raw = raw + (SUM_W'(dec_flat[DEC_W*k +: DEC_W]) << (NSTAGE - 1 - k));
    end
  end

  // Saturate instead of rolling over.
  assign code = (raw > CODE_MAX) ? {OUT_W{1'b1}} : raw[OUT_W-1:0];
endmodule

// File: rtl/adc_dig_correct.sv
`timescale 1ns/1ps
module adc_dig_correct
  import adc_corr_pkg::*;
#(
  parameter int unsigned NSTAGE  = 9,
  parameter int unsigned OUT_DLY = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    dec_valid,
  input  logic [2*NSTAGE-1:0]     stage_dec,
  input  logic                    twos_fmt,
  input  logic                    hiz_en,
  output logic                    out_valid,
  output logic [NSTAGE:0]         code_o
);
  localparam int unsigned OUT_W = NSTAGE + 1;

  stage_dec_t                aligned [NSTAGE];
  logic [DEC_W*NSTAGE-1:0]   aligned_flat;
  logic                      aligned_vld;
  logic [OUT_W-1:0]          merged;
  logic [OUT_W-1:0]          sum_q;
  logic                      sum_vld_q;
  logic [OUT_W-1:0]          tail_code;
  logic                      tail_vld;
  logic [OUT_W-1:0]          hold_q;
  logic                      vld_q;
  logic [OUT_W-1:0]          fmt_code;

  // Stage k reports k sub-cycles late, so it waits NSTAGE-k registers.
  for (genvar k = 0; k < int'(NSTAGE); k++) begin : g_align
    adc_delay_line #(.W(DEC_W), .DEPTH(NSTAGE - k)) u_dl (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (stage_dec[DEC_W*k +: DEC_W]),
      .q     (aligned[k])
    );
    assign aligned_flat[DEC_W*k +: DEC_W] = aligned[k];
  end

  adc_delay_line #(.W(1), .DEPTH(NSTAGE)) u_vld_dl (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (dec_valid),
    .q     (aligned_vld)
  );

  adc_overlap_merge #(.NSTAGE(NSTAGE)) u_merge (
    .dec_flat (aligned_flat),
    .code     (merged)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q     <= '0;
      sum_vld_q <= 1'b0;
    end else begin
      sum_q     <= merged;
      sum_vld_q <= aligned_vld;
    end
  end

  // Padding so the digital path spans NSTAGE+OUT_DLY sub-clock edges.
  if (OUT_DLY > 1) begin : g_pad
    adc_delay_line #(.W(OUT_W + 1), .DEPTH(OUT_DLY - 1)) u_pad (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({sum_vld_q, sum_q}),
      .q     ({tail_vld, tail_code})
    );
  end else begin : g_nopad
    assign tail_vld  = sum_vld_q;
    assign tail_code = sum_q;
  end

  // Result register loads only with a completed sample and holds between.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= tail_vld;
      if (tail_vld) hold_q <= tail_code;
    end
  end

  assign fmt_code  = {hold_q[OUT_W-1] ^ twos_fmt, hold_q[OUT_W-2:0]};
  assign out_valid = vld_q;
  assign code_o    = hiz_en ? {OUT_W{1'bz}} : fmt_code;
endmodule

// File: rtl/adc_dig_correct_chk.sv
`timescale 1ns/1ps
module adc_dig_correct_chk #(
  parameter int unsigned NSTAGE  = 9,
  parameter int unsigned OUT_DLY = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            dec_valid,
  input logic            twos_fmt,
  input logic            hiz_en,
  input logic            out_valid,
  input logic [NSTAGE:0] code_o
);
  localparam int unsigned OUT_W = NSTAGE + 1;
  localparam int unsigned LAT   = NSTAGE + OUT_DLY;
  localparam int unsigned CNT_W = $clog2(LAT + 1);

  logic [LAT:0]      strobe_hist;
  logic [CNT_W-1:0]  win_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_hist <= '0;
      win_cnt     <= '0;
    end else begin
      strobe_hist <= {strobe_hist[LAT-1:0], dec_valid};
      if (win_cnt < CNT_W'(LAT)) win_cnt <= win_cnt + 1'b1;
    end
  end

  assert_valid_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == strobe_hist[LAT]);

  assert_quiet_after_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (win_cnt < CNT_W'(LAT)) |-> !out_valid);

  assert_hold_between_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!hiz_en && !$past(hiz_en) && !out_valid) |->
      (code_o[OUT_W-2:0] == $past(code_o[OUT_W-2:0])));

  assert_msb_format_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!hiz_en && !$past(hiz_en) && !out_valid) |->
      ((code_o[OUT_W-1] ^ twos_fmt) == $past(code_o[OUT_W-1] ^ twos_fmt)));
endmodule

bind adc_dig_correct adc_dig_correct_chk #(.NSTAGE(NSTAGE), .OUT_DLY(OUT_DLY)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dec_valid (dec_valid),
  .twos_fmt  (twos_fmt),
  .hiz_en    (hiz_en),
  .out_valid (out_valid),
  .code_o    (code_o)
);

// File: tb/tb_adc_dig_correct.sv
`timescale 1ns/1ps
module tb_adc_dig_correct;
  localparam int NS   = 9;
  localparam int OW   = 10;
  localparam int LAT  = 13;
  localparam int NSMP = 297;
  localparam int MAXC = 1024;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic            rst_n = 1'b0;
  logic            dec_valid = 1'b0;
  logic [2*NS-1:0] stage_dec = '0;
  logic            twos_fmt = 1'b0;
  logic            hiz_en = 1'b0;
  logic            out_valid;
  wire  [OW-1:0]   code_bus;

  for (genvar gi = 0; gi < OW; gi++) begin : g_pd
    pulldown u_pd (code_bus[gi]);
  end

  adc_dig_correct dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .dec_valid (dec_valid),
    .stage_dec (stage_dec),
    .twos_fmt  (twos_fmt),
    .hiz_en    (hiz_en),
    .out_valid (out_valid),
    .code_o    (code_bus)
  );

  int checks = 0;
  int failures = 0;
  int edge_cnt = 0;
  always @(posedge clk) edge_cnt++;

  logic [2*NS-1:0] plan_dec [MAXC];
  logic            plan_vld [MAXC];
  int              plan_smp [MAXC];
  int              exp_code [NSMP];
  int              exp_raw  [NSMP];
  int              cap_edge [NSMP];
  int              wr_i = 0;
  int              rd_i = 0;
  int              last_c = 0;
  logic            mon_on = 1'b0;
  logic            have_last = 1'b0;
  int              last_code = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, expv, $time);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Decision of stage k for sample n
  function automatic int vval(input int n, input int k);
    int m;
    if (n < 36) return (k == n / 4) ? (n % 4) : 0;
    if (n == 36) return 0;
    if (n == 37) return 3;
    if (n == 38) return (k == 0) ? 2 : 0;
    if (n == 39) return (k < 2) ? 3 : 0;
    if (n == NSMP - 1) return 1;
    m = n - 40;
    if (k < 4) return (m >> (2 * k)) & 3;
    return ((m * 7 + k * 5) >> (k - 3)) & 3;
  endfunction

  function automatic int fmt_plan(input int c);
    return (c >= 200 && ((c / 48) % 2) == 1) ? 1 : 0;
  endfunction

  function automatic int apply_fmt(input int v, input logic f);
    return f ? (v ^ 512) : v;
  endfunction

  // Monitor away from the active edge
  always @(negedge clk) begin
    if (mon_on && !hiz_en) begin
      if (out_valid) begin
        if (rd_i >= wr_i) begin
          chk(1'b0, "R4 (unexpected out_valid)", 1, 0);
        end else begin
          int n;
          string tag;
          n = rd_i;
          if (twos_fmt) tag = "R6";
          else if (exp_raw[n] > 1023 || exp_raw[n] == 0) tag = "R3";
          else tag = "R1,R2";
          chk(int'(code_bus) == apply_fmt(exp_code[n], twos_fmt), tag,
              int'(code_bus), apply_fmt(exp_code[n], twos_fmt));
          chk(edge_cnt == cap_edge[n] + LAT, "R4 latency", edge_cnt, cap_edge[n] + LAT);
          last_code = exp_code[n];
          have_last = 1'b1;
          rd_i++;
        end
      end else if (have_last) begin
        chk(int'(code_bus) == apply_fmt(last_code, twos_fmt), "R8",
            int'(code_bus), apply_fmt(last_code, twos_fmt));
      end else begin
        chk(code_bus == '0, "R5", int'(code_bus), 0);
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    chk(1'b0, "R4 watchdog", rd_i, NSMP);
    finish_run();
  end

  initial begin
    int s;
    // Build the schedule: noise everywhere, then each stage in its own slot
    for (int c = 0; c < MAXC; c++) begin
      logic [31:0] h;
      h = 32'(c) * 32'h9E3779B1;
      plan_dec[c] = h[2*NS+6:7];
      plan_vld[c] = 1'b0;
      plan_smp[c] = 0;
    end
    s = 0;
    for (int n = 0; n < NSMP; n++) begin
      int raw;
      raw = 0;
      plan_vld[s] = 1'b1;
      plan_smp[s] = n;
      for (int k = 0; k < NS; k++) begin
        plan_dec[s + k][2*k +: 2] = 2'(vval(n, k));
        raw += vval(n, k) << (NS - 1 - k);
      end
      exp_raw[n]  = raw;
      exp_code[n] = (raw > 1023) ? 1023 : raw;
      s += ((n % 37) == 5) ? 5 : 2;
    end
    last_c = s + NS;

    // R5: reset state
    repeat (4) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R5 valid in reset", int'(out_valid), 0);
      chk(code_bus == '0, "R5 code in reset", int'(code_bus), 0);
    end
    @(posedge clk);
    #1 rst_n = 1'b1;
    mon_on = 1'b1;

    for (int c = 0; c < last_c; c++) begin
      @(posedge clk);
      #1;
      dec_valid = plan_vld[c];
      stage_dec = plan_dec[c];
      twos_fmt  = fmt_plan(c) != 0;
      if (plan_vld[c]) begin
        cap_edge[plan_smp[c]] = edge_cnt + 1;
        wr_i++;
      end
    end
    @(posedge clk);
    #1;
    dec_valid = 1'b0;
    stage_dec = '0;
    twos_fmt  = 1'b0;
    repeat (LAT + 6) @(posedge clk);
    #1;
    chk(rd_i == NSMP, "R4 result count", rd_i, NSMP);

    // R7 / R6 with the last result (511) held
    hiz_en = 1'b1;
    @(negedge clk);
    chk(code_bus == '0, "R7 floated", int'(code_bus), 0);
    @(posedge clk);
    #1 twos_fmt = 1'b1;
    @(negedge clk);
    chk(code_bus == '0, "R7 floated fmt", int'(code_bus), 0);
    @(posedge clk);
    #1 hiz_en = 1'b0;
    @(negedge clk);
    chk(int'(code_bus) == 1023, "R6 msb flip", int'(code_bus), 1023);
    @(posedge clk);
    #1 twos_fmt = 1'b0;
    @(negedge clk);
    chk(int'(code_bus) == 511, "R7 restored", int'(code_bus), 511);
    finish_run();
  end
endmodule